// File: doc/BRIEF.md
# Two-Wire Register Front End for a Quad Converter

This block sits between a two-wire serial bus and the register bank of a four-channel converter. It samples the bus clock and data lines on the system clock and pulls the data line low through an open-drain enable. It recognises bus START and STOP conditions and answers a 7-bit address. The upper six bits of that address are fixed. The lowest bit comes from a strap input, so two of these blocks can share one bus.

After the address, a write sends a selection byte. Its low four bits form a channel mask. One or more 16-bit data words follow, and each word lands in every selected channel. Once a word is complete, the selected channels' held values update and a one-cycle load pulse is issued.

Reads come in two forms. In the first, the selection byte is followed by a repeated START. In the second, the address alone is sent with the read bit set, and the previously stored selection is reused. Either way the block returns the word of the lowest-numbered selected channel.

Top module: `i2c_dac_regif`

## Requirements
- R1: While reset is asserted and immediately after it, every channel output reads zero, the data line is not pulled and the load pulse is low; the stored selection mask is zero.
- R2: The block acknowledges an address byte only when its upper seven bits equal 0001100 with the last of them replaced by the strap input; any other address is not acknowledged and the bytes that follow it change no channel.
- R3: For a matching address, an accepted selection byte and each write data byte, the block pulls the data line low during the ninth clock pulse, and it starts pulling only while the bus clock is low.
- R4: A data word is stored into every channel whose mask bit is set (bit 0 = channel 0 through bit 3 = channel 3); unselected channels keep their values.
- R5: A data word is two bytes, high byte first, each byte sent most significant bit first; the channel value is bits 15..4 of the word and bits 3..0 are ignored.
- R6: The channel outputs change only in the cycle in which the load pulse is high; the load pulse lasts one cycle and fires once per completed two-byte word.
- R7: A selection byte whose bits 5..4 are not both zero is not acknowledged, and data bytes after it change no channel.
- R8: After a selection byte and a repeated START with the read bit set, the block returns the selected channel's word as bits 15..4 = value and bits 3..0 = 0, high byte first, then alternating low and high bytes while the master acknowledges.
- R9: A read that sends only the address reuses the most recently stored selection; with several channels selected, the lowest-numbered one is returned.
- R10: A START or STOP part-way through a transfer abandons it: a word missing its second byte is never stored, and the data line is released.
- R11: When the master does not acknowledge a read byte, the block stops driving data and leaves the line released until the next START.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 8 times the bus clock rate |
| rst | input | 1 | Synchronous active-high reset |
| addr_strap | input | 1 | Selects the least significant address bit |
| scl_in | input | 1 | Bus clock line as seen at the pin |
| sda_in | input | 1 | Bus data line as seen at the pin |
| sda_pull | output | 1 | When high, the data line is driven low (open-drain enable) |
| chan_values | output | 48 | Four 12-bit held channel values, channel 0 in bits 11..0 |
| load_pulse | output | 1 | One-cycle strobe in the cycle the held values update |

## Verification
The hardest case to reach is a transfer cut off part-way through a data byte, after the high byte has already been accepted. In that case, only the absence of a store and of a load pulse shows that the partial word was discarded. The bench drives the bus bit by bit and so can stop after any bit. It sends four bits of a low byte and then issues a START, and it separately ends a transfer with a STOP right after a high byte. It then checks that the channel values and the load pulse count are unchanged. The address-only read is reached by storing a two-channel selection in a write that carries no data, so the later read shows both that the selection is reused and which channel has priority.

// File: rtl/dacif_pkg.sv
package dacif_pkg;
  localparam int WORD_W = 16;
  localparam int BYTE_W = 8;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_ADDR,
    PH_SEL,
    PH_WHI,
    PH_WLO,
    PH_READ,
    PH_SKIP
  } phase_t;
endpackage

// File: rtl/dacif_line_sync.sv
module dacif_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic scl_in,
  input  logic sda_in,
  output logic sda_lvl,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  logic [STAGES-1:0] scl_chain, sda_chain;
  logic scl_q, sda_q, scl_s;

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_chain <= '1;
      sda_chain <= '1;
      scl_q     <= 1'b1;
      sda_q     <= 1'b1;
    end else begin
      scl_chain <= {scl_chain[STAGES-2:0], scl_in};
      sda_chain <= {sda_chain[STAGES-2:0], sda_in};
      scl_q     <= scl_chain[STAGES-1];
      sda_q     <= sda_chain[STAGES-1];
    end
  end

  assign scl_s     = scl_chain[STAGES-1];
  assign sda_lvl   = sda_chain[STAGES-1];
  assign scl_rise  = scl_s & ~scl_q;
  assign scl_fall  = ~scl_s & scl_q;
  assign start_det = scl_s & scl_q & sda_q & ~sda_lvl;
  assign stop_det  = scl_s & scl_q & ~sda_q & sda_lvl;
endmodule

// File: rtl/dacif_proto.sv
module dacif_proto
  import dacif_pkg::*;
#(
  parameter int         NCH     = 4,
  parameter int         DW      = 12,
  parameter logic [5:0] ADDR_HI = 6'b000110
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           sda_lvl,
  input  logic           scl_rise,
  input  logic           scl_fall,
  input  logic           start_det,
  input  logic           stop_det,
  input  logic           addr_strap,
  input  logic [DW-1:0]  rd_val,
  output logic [NCH-1:0] sel_mask,
  output logic           sda_pull,
  output logic           wr_stb,
  output logic [NCH-1:0] wr_mask,
  output logic [DW-1:0]  wr_data
);
  localparam int PAD     = WORD_W - DW;
  localparam int RSV_TOP = 5;
  localparam int LO_BITS = DW - BYTE_W;

  phase_t      st, nxt;
  logic [3:0]  cnt;
  logic [7:0]  shreg, hi_q, tx_q;
  logic        mst_ack, rd_lo;
  logic [WORD_W-1:0] rd_word;
  logic [7:0]  next_byte;
  logic        addr_hit, sel_ok;

  assign rd_word   = {rd_val, {PAD{1'b0}}};
  assign next_byte = (st == PH_READ && rd_lo) ? rd_word[7:0] : rd_word[15:8];
  assign addr_hit  = (shreg[7:1] == {ADDR_HI, addr_strap});
  assign sel_ok    = (shreg[RSV_TOP:NCH] == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      st       <= PH_IDLE;
      nxt      <= PH_SKIP;
      cnt      <= '0;
      shreg    <= '0;
      hi_q     <= '0;
      tx_q     <= '0;
      mst_ack  <= 1'b0;
      rd_lo    <= 1'b0;
      sel_mask <= '0;
      sda_pull <= 1'b0;
      wr_stb   <= 1'b0;
      wr_mask  <= '0;
      wr_data  <= '0;
    end else begin
      wr_stb <= 1'b0;
      if (start_det) begin
        st       <= PH_ADDR;
        cnt      <= '0;
        sda_pull <= 1'b0;
      end else if (stop_det) begin
        st       <= PH_IDLE;
        cnt      <= '0;
        sda_pull <= 1'b0;
      end else if (st != PH_IDLE) begin
        if (scl_rise) begin
          if (cnt < 4'd8) shreg <= {shreg[6:0], sda_lvl};
          else if (st == PH_READ) mst_ack <= ~sda_lvl;
          cnt <= cnt + 4'd1;
        end else if (scl_fall) begin
          if (cnt == 4'd8) begin
            // byte complete: decide acknowledge and the phase after it
            nxt <= PH_SKIP;
            case (st)
              PH_ADDR: if (addr_hit) begin
                sda_pull <= 1'b1;
                nxt      <= shreg[0] ? PH_READ : PH_SEL;
              end
              PH_SEL: if (sel_ok) begin
                sda_pull <= 1'b1;
                sel_mask <= shreg[NCH-1:0];
                nxt      <= PH_WHI;
              end
              PH_WHI: begin
                sda_pull <= 1'b1;
                hi_q     <= shreg;
                nxt      <= PH_WLO;
              end
              PH_WLO: begin
                sda_pull <= 1'b1;
                wr_mask  <= sel_mask;
                wr_data  <= {hi_q, shreg[7 -: LO_BITS]};
                nxt      <= PH_WHI;
              end
              PH_READ: begin
                sda_pull <= 1'b0;
                nxt      <= PH_READ;
              end
              default: nxt <= PH_SKIP;
            endcase
          end else if (cnt == 4'd9) begin
            cnt <= '0;
            if (st == PH_WLO) wr_stb <= 1'b1;
            if (st == PH_READ && !mst_ack) begin
              st       <= PH_SKIP;
              sda_pull <= 1'b0;
            end else begin
              st <= nxt;
              if (nxt == PH_READ) begin
                tx_q     <= next_byte;
                sda_pull <= ~next_byte[7];
                rd_lo    <= (st == PH_READ) ? ~rd_lo : 1'b1;
              end else begin
                sda_pull <= 1'b0;
              end
            end
          end else if (st == PH_READ && cnt != 4'd0) begin
            tx_q     <= {tx_q[6:0], 1'b0};
            sda_pull <= ~tx_q[6];
          end
        end
      end
    end
  end
endmodule

// File: rtl/dacif_chan_bank.sv
module dacif_chan_bank #(
  parameter int NCH = 4,
  parameter int DW  = 12
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            wr_stb,
  input  logic [NCH-1:0]  wr_mask,
  input  logic [DW-1:0]   wr_data,
  input  logic [NCH-1:0]  sel_mask,
  output logic [DW-1:0]   rd_val,
  output logic [NCH*DW-1:0] chan_values,
  output logic            load_pulse
);
  logic [DW-1:0]  in_q  [NCH];
  logic [DW-1:0]  out_q [NCH];
  logic [NCH-1:0] pend;
  logic           pend_v;

  always_ff @(posedge clk) begin
    if (rst) begin
      pend       <= '0;
      pend_v     <= 1'b0;
      load_pulse <= 1'b0;
    end else begin
      pend       <= wr_stb ? wr_mask : '0;
      pend_v     <= wr_stb;
      load_pulse <= pend_v;
    end
  end

  for (genvar g = 0; g < NCH; g++) begin : g_chan
    always_ff @(posedge clk) begin
      if (rst) begin
        in_q[g]  <= '0;
        out_q[g] <= '0;
      end else begin
        if (wr_stb && wr_mask[g]) in_q[g] <= wr_data;
        if (pend[g])              out_q[g] <= in_q[g];
      end
    end
    assign chan_values[g*DW +: DW] = out_q[g];
  end

  // lowest-numbered selected channel wins the readback
  always_comb begin
    rd_val = '0;
    for (int i = NCH - 1; i >= 0; i--) begin
      if (sel_mask[i]) rd_val = in_q[i];
    end
  end
endmodule

// File: rtl/i2c_dac_regif.sv
module i2c_dac_regif #(
  parameter int         NCH         = 4,
  parameter int         DW          = 12,
  parameter int         SYNC_STAGES = 2,
  parameter logic [5:0] ADDR_HI     = 6'b000110
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              addr_strap,
  input  logic              scl_in,
  input  logic              sda_in,
  output logic              sda_pull,
  output logic [NCH*DW-1:0] chan_values,
  output logic              load_pulse
);
  logic           w_sda, w_rise, w_fall, w_start, w_stop;
  logic [DW-1:0]  w_rd_val;
  logic [NCH-1:0] w_sel, w_wr_mask;
  logic           w_wr_stb;
  logic [DW-1:0]  w_wr_data;

  dacif_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .scl_in(scl_in), .sda_in(sda_in),
    .sda_lvl(w_sda), .scl_rise(w_rise), .scl_fall(w_fall),
    .start_det(w_start), .stop_det(w_stop)
  );

  dacif_proto #(.NCH(NCH), .DW(DW), .ADDR_HI(ADDR_HI)) u_proto (
    .clk(clk), .rst(rst), .sda_lvl(w_sda), .scl_rise(w_rise),
    .scl_fall(w_fall), .start_det(w_start), .stop_det(w_stop),
    .addr_strap(addr_strap), .rd_val(w_rd_val), .sel_mask(w_sel),
    .sda_pull(sda_pull), .wr_stb(w_wr_stb), .wr_mask(w_wr_mask),
    .wr_data(w_wr_data)
  );

  dacif_chan_bank #(.NCH(NCH), .DW(DW)) u_bank (
    .clk(clk), .rst(rst), .wr_stb(w_wr_stb), .wr_mask(w_wr_mask),
    .wr_data(w_wr_data), .sel_mask(w_sel), .rd_val(w_rd_val),
    .chan_values(chan_values), .load_pulse(load_pulse)
  );
endmodule

// File: rtl/dacif_chk.sv
module dacif_chk #(
  parameter int W = 48
) (
  input logic         clk,
  input logic         rst,
  input logic         scl_in,
  input logic         sda_pull,
  input logic         load_pulse,
  input logic [W-1:0] chan_values,
  input logic         start_det,
  input logic         stop_det
);
  a_r1_reset_clear: assert property (@(posedge clk)
    rst |=> (chan_values == '0 && !sda_pull && !load_pulse));

  a_r6_single_cycle_load: assert property (@(posedge clk) disable iff (rst)
    load_pulse |=> !load_pulse);

  a_r6_update_only_on_load: assert property (@(posedge clk) disable iff (rst)
    (chan_values != $past(chan_values)) |-> load_pulse);

  a_r3_pull_while_scl_low: assert property (@(posedge clk) disable iff (rst)
    $rose(sda_pull) |-> !scl_in);

  a_r10_stop_releases: assert property (@(posedge clk) disable iff (rst)
    stop_det |=> !sda_pull);

  a_r10_start_releases: assert property (@(posedge clk) disable iff (rst)
    start_det |=> !sda_pull);
endmodule

bind i2c_dac_regif dacif_chk #(.W(NCH*DW)) u_chk (
  .clk(clk), .rst(rst), .scl_in(scl_in), .sda_pull(sda_pull),
  .load_pulse(load_pulse), .chan_values(chan_values),
  .start_det(w_start), .stop_det(w_stop)
);

// File: tb/test_i2c_dac_regif.sv
module test_i2c_dac_regif;
  localparam int CLK_PERIOD = 10;
  localparam int HP = 8;
  localparam int NCH = 4;
  localparam int DW = 12;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic strap = 1'b0;
  logic m_scl = 1'b1;
  logic m_sda = 1'b1;
  logic sda_pull, load_pulse;
  logic [NCH*DW-1:0] chan_values;
  logic sda_bus;

  int vectors = 0;
  int fails = 0;
  int pulses = 0;
  int doubles = 0;
  int cycles = 0;
  logic prev_load = 1'b0;
  logic [DW-1:0] exp_ch [NCH];

  assign sda_bus = m_sda & ~sda_pull;

  always #(CLK_PERIOD/2) clk = ~clk;

  i2c_dac_regif i_i2c_dac_regif (
    .clk(clk), .rst(rst), .addr_strap(strap), .scl_in(m_scl),
    .sda_in(sda_bus), .sda_pull(sda_pull), .chan_values(chan_values),
    .load_pulse(load_pulse)
  );

  always @(posedge clk) begin
    cycles <= cycles + 1;
    prev_load <= load_pulse;
    if (load_pulse) pulses <= pulses + 1;
    if (load_pulse && prev_load) doubles <= doubles + 1;
  end

  initial begin
    wait (cycles > 150000);
    fails++;
    $display("FAIL watchdog: run did not finish, actual %0d cycles expected < 150000", cycles);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic check_channels(input string req);
    for (int i = 0; i < NCH; i++)
      check(req, 32'(chan_values[i*DW +: DW]), 32'(exp_ch[i]));
  endtask

  task automatic bus_start();
    m_sda = 1'b1; tick(HP);
    m_scl = 1'b1; tick(HP);
    m_sda = 1'b0; tick(HP);
    m_scl = 1'b0;
  endtask

  task automatic bus_stop();
    tick(2); m_sda = 1'b0; tick(HP);
    m_scl = 1'b1; tick(HP);
    m_sda = 1'b1; tick(HP);
  endtask

  task automatic put_bit(input logic b);
    tick(2); m_sda = b; tick(HP);
    m_scl = 1'b1; tick(HP);
    m_scl = 1'b0;
  endtask

  task automatic get_bit(output logic b);
    tick(2); m_sda = 1'b1; tick(HP);
    m_scl = 1'b1; tick(HP/2);
    b = sda_bus; tick(HP/2);
    m_scl = 1'b0;
  endtask

  task automatic send_byte(input logic [7:0] d, output logic acked);
    logic b;
    for (int i = 7; i >= 0; i--) put_bit(d[i]);
    get_bit(b);
    acked = ~b;
  endtask

  task automatic recv_byte(input logic give_ack, output logic [7:0] d);
    logic b;
    for (int i = 7; i >= 0; i--) begin
      get_bit(b);
      d[i] = b;
    end
    put_bit(~give_ack);
  endtask

  task automatic write_word(input logic [7:0] addr, input logic [7:0] sel,
                            input logic [15:0] word, input string req,
                            input logic exp_ack);
    logic a;
    bus_start();
    send_byte(addr, a); check({req, " address ack"}, 32'(a), 32'(exp_ack));
    send_byte(sel, a);
    send_byte(word[15:8], a);
    send_byte(word[7:0], a);
    bus_stop();
    tick(4);
  endtask

  task automatic t_reset();
    check("R1 sda released", 32'(sda_pull), 0);
    check("R1 load low", 32'(load_pulse), 0);
    check_channels("R1 channels zero");
    check("R1 no load pulses", 32'(pulses), 0);
  endtask

  task automatic t_single_write();
    logic a;
    int p0 = pulses;
    bus_start();
    send_byte(8'h18, a); check("R2 matching address acked", 32'(a), 1);
    send_byte(8'h01, a); check("R3 selection acked", 32'(a), 1);
    send_byte(8'hAB, a); check("R3 high byte acked", 32'(a), 1);
    send_byte(8'hC5, a); check("R3 low byte acked", 32'(a), 1);
    bus_stop(); tick(4);
    exp_ch[0] = 12'hABC;
    check_channels("R5 value from bits 15..4, channel 0 only");
    check("R6 one load pulse per word", 32'(pulses - p0), 1);
  endtask

  task automatic t_multi_write();
    int p0 = pulses;
    write_word(8'h18, 8'h0E, 16'h123F, "R4", 1'b1);
    exp_ch[1] = 12'h123; exp_ch[2] = 12'h123; exp_ch[3] = 12'h123;
    check_channels("R4 mask writes channels 1..3, channel 0 kept");
    check("R6 single pulse for multi-channel word", 32'(pulses - p0), 1);
  endtask

  task automatic t_wrong_addr();
    int p0 = pulses;
    write_word(8'h1A, 8'h01, 16'h5550, "R2 mismatched", 1'b0);
    check_channels("R2 mismatched address changes nothing");
    check("R2 no pulse after mismatched address", 32'(pulses - p0), 0);
  endtask

  task automatic t_strap();
    strap = 1'b1;
    write_word(8'h1A, 8'h08, 16'hFFF0, "R2 strap high", 1'b1);
    exp_ch[3] = 12'hFFF;
    check_channels("R2 strap selects address bit 0");
    strap = 1'b0;
  endtask

  task automatic t_reserved_sel();
    logic a;
    int p0 = pulses;
    bus_start();
    send_byte(8'h18, a);
    send_byte(8'h11, a); check("R7 reserved bits set: no ack", 32'(a), 0);
    send_byte(8'h99, a);
    send_byte(8'h90, a);
    bus_stop(); tick(4);
    check_channels("R7 data after bad selection ignored");
    check("R7 no pulse", 32'(pulses - p0), 0);
  endtask

  task automatic t_read_restart();
    logic a;
    logic [7:0] d;
    write_word(8'h18, 8'h04, 16'h456A, "R4 channel 2", 1'b1);
    exp_ch[2] = 12'h456;
    check_channels("R4 channel 2 only");
    bus_start();
    send_byte(8'h18, a);
    send_byte(8'h02, a);
    bus_start();
    send_byte(8'h19, a); check("R8 read address acked", 32'(a), 1);
    recv_byte(1'b1, d); check("R8 high byte first", 32'(d), 32'h12);
    recv_byte(1'b0, d); check("R8 low byte, low nibble zero", 32'(d), 32'h30);
    tick(6);
    check("R11 released after master nack", 32'(sda_pull), 0);
    bus_stop();
    check("R11 still released at stop", 32'(sda_pull), 0);
  endtask

  task automatic t_addr_only_read();
    logic a;
    logic [7:0] d;
    int p0 = pulses;
    bus_start();
    send_byte(8'h18, a);
    send_byte(8'h0C, a); check("R9 selection-only write acked", 32'(a), 1);
    bus_stop(); tick(4);
    check("R9 selection-only write gives no pulse", 32'(pulses - p0), 0);
    bus_start();
    send_byte(8'h19, a); check("R9 address-only read acked", 32'(a), 1);
    recv_byte(1'b1, d); check("R9 lowest selected channel high byte", 32'(d), 32'h45);
    recv_byte(1'b1, d); check("R9 lowest selected channel low byte", 32'(d), 32'h60);
    recv_byte(1'b0, d); check("R8 wraps to high byte", 32'(d), 32'h45);
    bus_stop(); tick(4);
  endtask

  task automatic t_abort();
    logic a;
    int p0 = pulses;
    bus_start();
    send_byte(8'h18, a);
    send_byte(8'h01, a);
    send_byte(8'hEE, a);
    for (int i = 0; i < 4; i++) put_bit(1'b0);
    bus_start();
    tick(4);
    check("R10 start mid-byte releases line", 32'(sda_pull), 0);
    bus_stop(); tick(4);
    check_channels("R10 partial word after START not stored");
    bus_start();
    send_byte(8'h18, a);
    send_byte(8'h01, a);
    send_byte(8'h33, a); check("R3 high byte acked before stop", 32'(a), 1);
    bus_stop(); tick(4);
    check("R10 released after stop", 32'(sda_pull), 0);
    check_channels("R10 word cut by STOP not stored");
    check("R10 no pulse for abandoned words", 32'(pulses - p0), 0);
  endtask

  initial begin
    for (int i = 0; i < NCH; i++) exp_ch[i] = '0;
    tick(5);
    rst = 1'b0;
    tick(5);
    t_reset();
    t_single_write();
    t_multi_write();
    t_wrong_addr();
    t_strap();
    t_reserved_sel();
    t_read_restart();
    t_addr_only_read();
    t_abort();
    check("R6 load pulse never wider than one cycle", 32'(doubles), 0);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule